// File: doc/BRIEF.md
# 9-bit Multi-drop Address Filter

This block sits between a UART's receive and transmit paths and its FIFOs. It adds nine-bit multi-drop addressing for RS-422/RS-485 buses. When multi-drop operation is on, every character carries a ninth marker bit. A set marker means the character is a node address, and a clear marker means it is payload.

On receive, the block compares each address character in hardware against the node's own address, which is held in a compare register. After a match it opens a gate that lets the following payload bytes through to the receive FIFO. After a mismatch it closes that gate. The address byte itself is dropped unless an option input asks for a matching address to be kept.

On transmit, a write to the transmit-address register produces a nine-bit frame with the marker set. A write to the ordinary holding register produces a frame with the marker clear. With multi-drop operation off, the block passes plain 8-bit characters straight through.

Top module: `mdrop_addr_filter`

## Requirements
- R1: With `md_enable` low, every received character with `rx_valid` high appears one cycle later on `rxf_valid`/`rxf_data` as its low 8 bits; bit 8 is ignored.
- R2: After reset, and after any cycle with `md_enable` low, the filter is not addressed: payload characters (bit 8 = 0) are dropped until a matching address arrives.
- R3: In multi-drop mode, an address character (bit 8 = 1) whose low byte equals `own_addr` opens the gate; later payload characters are delivered one cycle after arrival.
- R4: An address character whose low byte differs from `own_addr` closes the gate; later payload characters are dropped.
- R5: An address character reaches `rxf_valid` only when it matches and `keep_addr` is 1; a non-matching address is never delivered.
- R6: In multi-drop mode, a `txa_wr` pulse produces `tx_valid` one cycle later with `tx_word` = {1'b1, `txa_byte`}.
- R7: A `thr_wr` pulse without a simultaneous transmit-address frame produces `tx_valid` one cycle later with `tx_word` = {1'b0, `thr_byte`}, in either mode.
- R8: With `md_enable` low, `txa_wr` sends nothing, because the register then serves as scratch storage.
- R9: If `txa_wr` (in multi-drop mode) and `thr_wr` arrive in the same cycle, the address frame is sent and the holding-register write is discarded.
- R10: `rxf_valid` is high only in the cycle after a cycle in which `rx_valid` was high, and `tx_valid` only in the cycle after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| md_enable | input | 1 | Multi-drop (nine-bit) mode enable |
| keep_addr | input | 1 | Deliver matching address bytes to the receive FIFO |
| own_addr | input | 8 | Node address compare value |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | 9 | Received character, bit 8 is the address marker |
| rxf_valid | output | 1 | Write strobe to the receive FIFO |
| rxf_data | output | 8 | Byte to the receive FIFO |
| txa_wr | input | 1 | Transmit-address register write |
| txa_byte | input | 8 | Address byte to send |
| thr_wr | input | 1 | Holding-register write |
| thr_byte | input | 8 | Payload byte to send |
| tx_valid | output | 1 | Frame strobe to the transmitter |
| tx_word | output | 9 | Nine-bit frame to the transmitter |

## Verification
The hardest state to reach from the ports is the re-lock after disabling: the gate has to be opened by a match, then mode must be dropped for only one cycle and raised again, and the next payload must be dropped. The stimulus builds this case with a matching address followed by delivered payload, a one-cycle disable and a payload byte. The address byte sits beside the payload so that a gate that survives the disable shows up at `rxf_valid`.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;
  localparam int BYTE_W = 8;
  localparam int CHAR_W = BYTE_W + 1;
  localparam int MARK_B = CHAR_W - 1;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [CHAR_W-1:0] char_t;

  function automatic logic is_addr(char_t c);
    return c[MARK_B];
  endfunction

  function automatic logic addr_hit(char_t c, byte_t own);
    return c[MARK_B] && (c[BYTE_W-1:0] == own);
  endfunction

  function automatic char_t frame(logic mark, byte_t b);
    return {mark, b};
  endfunction
endpackage

// File: rtl/mdrop_rx_gate.sv
module mdrop_rx_gate
  import mdrop_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  md_enable,
  input  logic  keep_addr,
  input  byte_t own_addr,
  input  logic  rx_valid,
  input  char_t rx_char,
  output logic  rxf_valid,
  output byte_t rxf_data,
  output logic  addressed,
  output logic  ev_hit,
  output logic  ev_miss
);
  logic pass_now;

  always_comb begin
    ev_hit  = rx_valid && md_enable && addr_hit(rx_char, own_addr);
    ev_miss = rx_valid && md_enable && is_addr(rx_char) && !addr_hit(rx_char, own_addr);
    if (!md_enable)
      pass_now = rx_valid;
    else if (is_addr(rx_char))
      pass_now = ev_hit && keep_addr;
    else
      pass_now = rx_valid && addressed;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addressed <= 1'b0;
    end else if (!md_enable) begin
      addressed <= 1'b0;
    end else if (ev_hit) begin
      addressed <= 1'b1;
    end else if (ev_miss) begin
      addressed <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxf_valid <= 1'b0;
      rxf_data  <= '0;
    end else begin
      rxf_valid <= pass_now;
      if (rx_valid) rxf_data <= rx_char[BYTE_W-1:0];
    end
  end
endmodule

// File: rtl/mdrop_tx_framer.sv
module mdrop_tx_framer
  import mdrop_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  md_enable,
  input  logic  txa_wr,
  input  byte_t txa_byte,
  input  logic  thr_wr,
  input  byte_t thr_byte,
  output logic  tx_valid,
  output char_t tx_word,
  output logic  ev_tx_addr,
  output logic  ev_tx_data
);
  always_comb begin
    ev_tx_addr = txa_wr && md_enable;
    ev_tx_data = thr_wr && !ev_tx_addr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_word  <= '0;
    end else begin
      tx_valid <= ev_tx_addr || ev_tx_data;
      if (ev_tx_addr)
        tx_word <= frame(1'b1, txa_byte);
      else if (ev_tx_data)
        tx_word <= frame(1'b0, thr_byte);
    end
  end
endmodule

// File: rtl/mdrop_addr_filter.sv
module mdrop_addr_filter
  import mdrop_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              md_enable,
  input  logic              keep_addr,
  input  logic [BYTE_W-1:0] own_addr,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_char,
  output logic              rxf_valid,
  output logic [BYTE_W-1:0] rxf_data,
  input  logic              txa_wr,
  input  logic [BYTE_W-1:0] txa_byte,
  input  logic              thr_wr,
  input  logic [BYTE_W-1:0] thr_byte,
  output logic              tx_valid,
  output logic [CHAR_W-1:0] tx_word
);
  logic addressed;
  logic ev_hit;
  logic ev_miss;
  logic ev_tx_addr;
  logic ev_tx_data;

  mdrop_rx_gate u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .md_enable (md_enable),
    .keep_addr (keep_addr),
    .own_addr  (own_addr),
    .rx_valid  (rx_valid),
    .rx_char   (rx_char),
    .rxf_valid (rxf_valid),
    .rxf_data  (rxf_data),
    .addressed (addressed),
    .ev_hit    (ev_hit),
    .ev_miss   (ev_miss)
  );

  mdrop_tx_framer u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .md_enable  (md_enable),
    .txa_wr     (txa_wr),
    .txa_byte   (txa_byte),
    .thr_wr     (thr_wr),
    .thr_byte   (thr_byte),
    .tx_valid   (tx_valid),
    .tx_word    (tx_word),
    .ev_tx_addr (ev_tx_addr),
    .ev_tx_data (ev_tx_data)
  );
endmodule

// File: rtl/mdrop_addr_filter_chk.sv
module mdrop_addr_filter_chk
  import mdrop_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              md_enable,
  input logic              keep_addr,
  input logic [BYTE_W-1:0] own_addr,
  input logic              rx_valid,
  input logic [CHAR_W-1:0] rx_char,
  input logic              rxf_valid,
  input logic [BYTE_W-1:0] rxf_data,
  input logic              txa_wr,
  input logic [BYTE_W-1:0] txa_byte,
  input logic              thr_wr,
  input logic [BYTE_W-1:0] thr_byte,
  input logic              tx_valid,
  input logic [CHAR_W-1:0] tx_word,
  input logic              addressed,
  input logic              ev_hit,
  input logic              ev_miss,
  input logic              ev_tx_addr,
  input logic              ev_tx_data
);
  AST_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !md_enable) |=> (rxf_valid && rxf_data == $past(rx_char[BYTE_W-1:0]))); // R1
  AST_DISABLE_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    !md_enable |=> !addressed); // R2
  AST_HIT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |=> addressed); // R3
  AST_MISS_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |=> (!addressed && !rxf_valid)); // R4
  AST_ADDR_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && md_enable && rx_char[MARK_B] && !keep_addr) |=> !rxf_valid); // R5
  AST_TX_ADDR_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (txa_wr && md_enable) |=> (tx_valid && tx_word == {1'b1, $past(txa_byte)})); // R6
  AST_TX_DATA_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && !txa_wr) |=> (tx_valid && tx_word == {1'b0, $past(thr_byte)})); // R7
  AST_TXA_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (txa_wr && !md_enable && !thr_wr) |=> !tx_valid); // R8
  AST_TX_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx_addr && thr_wr) |-> !ev_tx_data); // R9
  AST_RX_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> !rxf_valid); // R10
  AST_TX_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!txa_wr && !thr_wr) |=> !tx_valid); // R10
endmodule

bind mdrop_addr_filter mdrop_addr_filter_chk u_chk (.*);

// File: tb/mdrop_addr_filter_tb.sv
module mdrop_addr_filter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 20000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       md_enable, keep_addr;
  logic [7:0] own_addr;
  logic       rx_valid;
  logic [8:0] rx_char;
  logic       rxf_valid;
  logic [7:0] rxf_data;
  logic       txa_wr, thr_wr;
  logic [7:0] txa_byte, thr_byte;
  logic       tx_valid;
  logic [8:0] tx_word;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdrop_addr_filter u_dut (
    .clk(clk), .rst_n(rst_n), .md_enable(md_enable), .keep_addr(keep_addr),
    .own_addr(own_addr), .rx_valid(rx_valid), .rx_char(rx_char),
    .rxf_valid(rxf_valid), .rxf_data(rxf_data), .txa_wr(txa_wr),
    .txa_byte(txa_byte), .thr_wr(thr_wr), .thr_byte(thr_byte),
    .tx_valid(tx_valid), .tx_word(tx_word)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  // drive one received character, check the FIFO side one cycle later
  task automatic rx_step(string req, logic [8:0] ch, logic exp_v, logic [7:0] exp_d);
    rx_valid = 1'b1;
    rx_char  = ch;
    @(negedge clk);
    rx_valid = 1'b0;
    check(req, {15'd0, rxf_valid}, {15'd0, exp_v});
    if (exp_v) check(req, {8'd0, rxf_data}, {8'd0, exp_d});
  endtask

  task automatic tx_step(string req, logic aw, logic [7:0] ab, logic dw, logic [7:0] db,
                         logic exp_v, logic [8:0] exp_w);
    txa_wr = aw; txa_byte = ab; thr_wr = dw; thr_byte = db;
    @(negedge clk);
    txa_wr = 1'b0; thr_wr = 1'b0;
    check(req, {15'd0, tx_valid}, {15'd0, exp_v});
    if (exp_v) check(req, {7'd0, tx_word}, {7'd0, exp_w});
  endtask

  task automatic t_reset();
    check("R10 reset rxf", {15'd0, rxf_valid}, 16'd0);
    check("R10 reset tx", {15'd0, tx_valid}, 16'd0);
  endtask

  task automatic t_transparent();
    md_enable = 1'b0; idle();
    rx_step("R1 marker ignored", 9'h1A5, 1'b1, 8'hA5);
    rx_step("R1 plain byte", 9'h03C, 1'b1, 8'h3C);
    idle();
    check("R10 idle rx", {15'd0, rxf_valid}, 16'd0);
  endtask

  task automatic t_locked_out();
    md_enable = 1'b1; own_addr = 8'h42; keep_addr = 1'b0; idle();
    rx_step("R2 data before address", 9'h011, 1'b0, 8'h00);
  endtask

  task automatic t_match();
    rx_step("R5 matching addr hidden", 9'h142, 1'b0, 8'h00);
    rx_step("R3 data after match", 9'h077, 1'b1, 8'h77);
    rx_step("R3 second data", 9'h088, 1'b1, 8'h88);
  endtask

  task automatic t_mismatch();
    rx_step("R5 other addr hidden", 9'h155, 1'b0, 8'h00);
    rx_step("R4 data after mismatch", 9'h099, 1'b0, 8'h00);
  endtask

  task automatic t_keep();
    keep_addr = 1'b1;
    rx_step("R5 keep matching addr", 9'h142, 1'b1, 8'h42);
    rx_step("R5 keep no mismatch", 9'h143, 1'b0, 8'h00);
    rx_step("R4 closed after keep miss", 9'h021, 1'b0, 8'h00);
    keep_addr = 1'b0;
  endtask

  task automatic t_reenable();
    rx_step("R3 reopen", 9'h142, 1'b0, 8'h00);
    rx_step("R3 reopened data", 9'h05A, 1'b1, 8'h5A);
    md_enable = 1'b0; idle();
    md_enable = 1'b1;
    rx_step("R2 re-enable locks", 9'h05B, 1'b0, 8'h00);
  endtask

  task automatic t_tx();
    md_enable = 1'b1;
    tx_step("R6 address frame", 1'b1, 8'h42, 1'b0, 8'h00, 1'b1, 9'h142);
    tx_step("R7 data frame", 1'b0, 8'h00, 1'b1, 8'hAB, 1'b1, 9'h0AB);
    tx_step("R9 collision", 1'b1, 8'h17, 1'b1, 8'hEE, 1'b1, 9'h117);
    idle();
    check("R10 idle tx", {15'd0, tx_valid}, 16'd0);
    md_enable = 1'b0;
    tx_step("R8 scratch write silent", 1'b1, 8'h33, 1'b0, 8'h00, 1'b0, 9'h000);
    tx_step("R7 data frame mode off", 1'b0, 8'h00, 1'b1, 8'hCD, 1'b1, 9'h0CD);
    tx_step("R7 both writes mode off", 1'b1, 8'h66, 1'b1, 8'h12, 1'b1, 9'h012);
  endtask

  initial begin
    rst_n = 1'b0; md_enable = 1'b0; keep_addr = 1'b0; own_addr = 8'h00;
    rx_valid = 1'b0; rx_char = '0; txa_wr = 1'b0; thr_wr = 1'b0;
    txa_byte = '0; thr_byte = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();
    t_reset();
    t_transparent();
    t_locked_out();
    t_match();
    t_mismatch();
    t_keep();
    t_reenable();
    t_tx();
    done = 1;
  end

  initial begin
    for (int i = 0; i < WATCHDOG_CYC && !done; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule